// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Bank

This block is the software-visible control face of a two-channel DMA engine. One channel serves a disk controller and the other serves a network controller. Eight 32-bit word registers sit behind a simple synchronous bus: writes take effect on the clock edge and reads return data in the same cycle. Two of the registers are per-channel control words. Each control word carries an interrupt enable, a peripheral reset command and a fixed version tag in its top nibble. The disk control word also has a peculiar write rule for bit 6. It has a "loaded" flag that is set whenever software programs the disk address, and a pending flag that hardware sets on transfer-complete events.

On the hardware side, the disk mover reports each finished transfer with a strobe and a byte count. The bank then advances the disk address register by that count. Separate raise and clear strobes drive each channel's interrupt line. The bank emits a one-cycle reset pulse towards a peripheral when software writes that channel's reset command. It also exports the disk address and the network base register to the mover.

Top module: `dma_regbank`

## Requirements
- R1: The register index is bus_addr[4:2]; bus_addr[1:0] are ignored. bus_rdata shows the indexed register combinationally, with no wait state.
- R2: After reset, registers 0 and 4 read 0xA0000000, all other registers read 0, and both interrupt lines and both reset pulses are low.
- R3: A write to register 0 or 4 stores bits [27:0] of the data (after the R6 rule for register 0). Bits [31:28] always read 0xA.
- R4: A control write with bit 4 clear drives that channel's interrupt line low from the next cycle, unless a raise strobe for the same channel arrives in the same cycle.
- R5: A control write with bit 7 set gives a one-cycle high pulse on that channel's reset output, in the cycle after the write edge. The other channel's output stays low. Bit 7 is stored as written.
- R6: For register 0 only, the stored value of bit 6 is decided in this order. If bit 7 is written 1, bit 6 is kept as written. Otherwise a written 1 in bit 6 is stored as 0. Otherwise an all-zero write stores 0x40 (read back 0xA0000040). Register 4 has no such rule.
- R7: Any write to register 1 stores the data in register 1 and sets bit 26 of register 0. No other register 0 bit changes.
- R8: A dsk_done strobe sets register 0 bit 0 and adds dsk_len to register 1, modulo 2^32. It does not change dsk_irq. A register 1 write in the same cycle wins over the addition.
- R9: dsk_irq_raise sets register 0 bit 0 and drives dsk_irq high, whatever the enable bit holds. dsk_irq_clear clears bit 0 and drives dsk_irq low. If both strobes arrive in the same cycle, the clear wins.
- R10: net_irq_raise drives net_irq high and net_irq_clear drives it low, with the clear winning. Neither strobe touches the disk interrupt.
- R11: Registers 2, 3, 5, 6 and 7 are plain read/write storage. dsk_addr always equals register 1 and net_base always equals register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| dsk_done | input | 1 | Disk transfer-complete strobe |
| dsk_len | input | LEN_W | Byte count of the finished disk transfer |
| dsk_irq_raise | input | 1 | Disk interrupt raise strobe |
| dsk_irq_clear | input | 1 | Disk interrupt clear strobe |
| net_irq_raise | input | 1 | Network interrupt raise strobe |
| net_irq_clear | input | 1 | Network interrupt clear strobe |
| dsk_irq | output | 1 | Disk channel interrupt line |
| net_irq | output | 1 | Network channel interrupt line |
| dsk_periph_rst | output | 1 | One-cycle reset pulse to the disk peripheral |
| net_periph_rst | output | 1 | One-cycle reset pulse to the network peripheral |
| dsk_addr | output | 32 | Current disk address (register 1) |
| net_base | output | 32 | Network base value (register 7) |

## Verification
Collisions are the hardest situations to reach from the ports. A register 1 write must land on the same edge as a done strobe, and a raise must coincide with a clear. The bench reaches them by driving both inputs in one negative-edge window before a single rising edge, then reading back the winner. The bit 6 priority needs four writes that differ only in bits 6 and 7. The version-nibble forcing needs a write of all ones and a write of 0xF0000000, which is not zero, so it must not take the 0x40 path.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int WORD_W  = 32;
  localparam int NREG    = 8;
  localparam int IDX_W   = $clog2(NREG);
  localparam int BADDR_W = IDX_W + 2;

  localparam int IDX_DSK_CTL  = 0;
  localparam int IDX_DSK_ADR  = 1;
  localparam int IDX_NET_CTL  = 4;
  localparam int IDX_NET_BASE = 7;

  localparam int BIT_PEND   = 0;
  localparam int BIT_IEN    = 4;
  localparam int BIT_ALT    = 6;
  localparam int BIT_RSTCMD = 7;
  localparam int BIT_LOADED = 26;

  localparam int         VER_W   = 4;
  localparam logic [3:0] VER_TAG = 4'hA;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t reset_value(int idx);
    word_t v;
    v = '0;
    if (idx == IDX_DSK_CTL || idx == IDX_NET_CTL) v[WORD_W-1 -: VER_W] = VER_TAG;
    return v;
  endfunction

  function automatic word_t ctrl_write_value(word_t w, bit alt_rule);
    word_t v;
    v = w;
    if (alt_rule && !w[BIT_RSTCMD]) begin
      if (w[BIT_ALT]) v[BIT_ALT] = 1'b0;
      else if (w == '0) v = word_t'(1) << BIT_ALT;
    end
    v[WORD_W-1 -: VER_W] = VER_TAG;
    return v;
  endfunction

  function automatic word_t addr_advance(word_t a, word_t len);
    return a + len;
  endfunction
endpackage

// File: rtl/dmarb_store_reg.sv
module dmarb_store_reg
  import dma_regbank_pkg::*;
#(
  parameter word_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  output word_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wdata;
  end

  p_plain_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));
endmodule

// File: rtl/dmarb_addr_ctr.sv
module dmarb_addr_ctr
  import dma_regbank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  word_t            wdata,
  input  logic             adv,
  input  logic [LEN_W-1:0] adv_len,
  output word_t            q
);
  word_t step;
  assign step = word_t'(adv_len);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
    else if (adv)   q <= addr_advance(q, step);
  end

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> q == $past(q) + WORD_W'($past(adv_len)));
  p_addr_wrwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));
endmodule

// File: rtl/dmarb_ctrl_chan.sv
module dmarb_ctrl_chan
  import dma_regbank_pkg::*;
#(
  parameter bit IS_DISK = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  input  word_t set_mask,
  input  word_t clr_mask,
  input  logic  irq_raise,
  input  logic  irq_clear,
  output word_t ctrl_q,
  output logic  irq_o,
  output logic  prst_o
);
  word_t wr_val, ctrl_d;
  logic  ien_off_wr, rst_cmd_wr;

  assign wr_val     = ctrl_write_value(wdata, IS_DISK);
  assign ien_off_wr = wr_en && !wdata[BIT_IEN];
  assign rst_cmd_wr = wr_en && wdata[BIT_RSTCMD];

  always_comb begin
    ctrl_d = wr_en ? wr_val : ctrl_q;
    ctrl_d = (ctrl_d | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= reset_value(IS_DISK ? IDX_DSK_CTL : IDX_NET_CTL);
      irq_o  <= 1'b0;
      prst_o <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      prst_o <= rst_cmd_wr;
      if (irq_clear)       irq_o <= 1'b0;
      else if (irq_raise)  irq_o <= 1'b1;
      else if (ien_off_wr) irq_o <= 1'b0;
    end
  end

  p_version_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q[WORD_W-1 -: VER_W] == VER_TAG);
  p_ien_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_off_wr && !irq_raise) |=> !irq_o);
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> $past(wr_en && wdata[BIT_RSTCMD]));
  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_o && !rst_cmd_wr) |=> !prst_o);

  if (IS_DISK) begin : g_disk_chk
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear |=> (!irq_o && !ctrl_q[BIT_PEND]));
    p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raise && !irq_clear) |=> (irq_o && ctrl_q[BIT_PEND]));
  end else begin : g_net_chk
    p_net_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raise && !irq_clear) |=> irq_o);
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [BADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               dsk_done,
  input  logic [LEN_W-1:0]   dsk_len,
  input  logic               dsk_irq_raise,
  input  logic               dsk_irq_clear,
  input  logic               net_irq_raise,
  input  logic               net_irq_clear,
  output logic               dsk_irq,
  output logic               net_irq,
  output logic               dsk_periph_rst,
  output logic               net_periph_rst,
  output logic [WORD_W-1:0]  dsk_addr,
  output logic [WORD_W-1:0]  net_base
);
  logic [IDX_W-1:0] reg_idx;
  logic [NREG-1:0]  wr_sel;
  word_t            reg_q [NREG];
  logic             wr_dsk_adr;
  word_t            dsk_set, dsk_clr;
  logic             unused_lsb;

  assign reg_idx    = bus_addr[BADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  always_comb begin
    wr_sel = '0;
    if (bus_sel && bus_we) wr_sel[reg_idx] = 1'b1;
  end

  assign wr_dsk_adr = wr_sel[IDX_DSK_ADR];
  assign dsk_set    = (wr_dsk_adr ? (word_t'(1) << BIT_LOADED) : '0)
                    | ((dsk_done || dsk_irq_raise) ? (word_t'(1) << BIT_PEND) : '0);
  assign dsk_clr    = dsk_irq_clear ? (word_t'(1) << BIT_PEND) : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_DSK_CTL) begin : g_dctl
      dmarb_ctrl_chan #(.IS_DISK(1'b1)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]), .wdata(bus_wdata),
        .set_mask(dsk_set), .clr_mask(dsk_clr),
        .irq_raise(dsk_irq_raise), .irq_clear(dsk_irq_clear),
        .ctrl_q(reg_q[i]), .irq_o(dsk_irq), .prst_o(dsk_periph_rst));
    end else if (i == IDX_NET_CTL) begin : g_nctl
      dmarb_ctrl_chan #(.IS_DISK(1'b0)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]), .wdata(bus_wdata),
        .set_mask('0), .clr_mask('0),
        .irq_raise(net_irq_raise), .irq_clear(net_irq_clear),
        .ctrl_q(reg_q[i]), .irq_o(net_irq), .prst_o(net_periph_rst));
    end else if (i == IDX_DSK_ADR) begin : g_adr
      dmarb_addr_ctr #(.LEN_W(LEN_W)) u_adr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]), .wdata(bus_wdata),
        .adv(dsk_done), .adv_len(dsk_len), .q(reg_q[i]));
    end else begin : g_plain
      dmarb_store_reg #(.RST_VAL(reset_value(i))) u_st (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]), .wdata(bus_wdata),
        .q(reg_q[i]));
    end
  end

  assign bus_rdata = reg_q[reg_idx];
  assign dsk_addr  = reg_q[IDX_DSK_ADR];
  assign net_base  = reg_q[IDX_NET_BASE];

  p_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dsk_adr |=> reg_q[IDX_DSK_CTL][BIT_LOADED]);
  p_done_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_done && !dsk_irq_clear) |=> reg_q[IDX_DSK_CTL][BIT_PEND]);
  p_net_iso_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsk_irq_raise && !dsk_irq_clear && !wr_sel[IDX_DSK_CTL]) |=> $stable(dsk_irq));
endmodule

// File: tb/dma_regbank_bench.sv
module dma_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        dsk_done = 0, dsk_irq_raise = 0, dsk_irq_clear = 0;
  logic        net_irq_raise = 0, net_irq_clear = 0;
  logic [LW-1:0] dsk_len = 0;
  logic        dsk_irq, net_irq, dsk_periph_rst, net_periph_rst;
  logic [31:0] dsk_addr, net_base;

  int checks = 0, errors = 0;
  logic pr_d, pr_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regbank #(.LEN_W(LW)) u_dma_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dsk_done(dsk_done), .dsk_len(dsk_len), .dsk_irq_raise(dsk_irq_raise),
    .dsk_irq_clear(dsk_irq_clear), .net_irq_raise(net_irq_raise),
    .net_irq_clear(net_irq_clear), .dsk_irq(dsk_irq), .net_irq(net_irq),
    .dsk_periph_rst(dsk_periph_rst), .net_periph_rst(net_periph_rst),
    .dsk_addr(dsk_addr), .net_base(net_base));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_dctl(input logic [31:0] w);
    logic [31:0] r;
    case ({w[7], w[6]})
      2'b01:   r = w ^ 32'h40;
      2'b00:   r = (w == 0) ? 32'h40 : w;
      default: r = w;
    endcase
    return {4'hA, r[27:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    pr_d = dsk_periph_rst; pr_n = net_periph_rst;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk(v == ((i == 0 || i == 4) ? 32'hA0000000 : 32'h0), "R2 reset value", v,
          (i == 0 || i == 4) ? 32'hA0000000 : 32'h0);
    end
    chk({dsk_irq, net_irq, dsk_periph_rst, net_periph_rst} == 0, "R2 reset outputs",
        {28'h0, dsk_irq, net_irq, dsk_periph_rst, net_periph_rst}, 0);
  endtask

  task automatic t_ctrl_writes();
    logic [31:0] v;
    logic [31:0] pats [6] = '{32'hC0, 32'h40, 32'h0, 32'h50, 32'hFFFFFFFF, 32'hF0000000};
    do_reset();
    foreach (pats[k]) begin
      wr(5'h00, pats[k]);
      chk(pr_d == pats[k][7], "R5 disk pulse", 32'(pr_d), 32'(pats[k][7]));
      chk(pr_n == 0, "R5 other channel quiet", 32'(pr_n), 0);
      rd(5'h00, v);
      chk(v == model_dctl(pats[k]), "R6/R3 reg0 stored", v, model_dctl(pats[k]));
      chk(dsk_periph_rst == 0, "R5 pulse one cycle", 32'(dsk_periph_rst), 0);
    end
    wr(5'h12, 32'h0);
    rd(5'h10, v);
    chk(v == 32'hA0000000, "R6 no rule on reg4 / R1 low bits", v, 32'hA0000000);
    wr(5'h10, 32'h5FFFFFFF);
    chk(pr_n == 1 && pr_d == 0, "R5 net pulse", {30'h0, pr_n, pr_d}, 32'h2);
    rd(5'h10, v);
    chk(v == 32'hAFFFFFFF, "R3 reg4 version nibble", v, 32'hAFFFFFFF);
  endtask

  task automatic t_loaded_done();
    logic [31:0] v;
    do_reset();
    wr(5'h00, 32'h10);
    wr(5'h04, 32'h1000);
    rd(5'h00, v);
    chk(v == 32'hA4000010, "R7 loaded flag", v, 32'hA4000010);
    chk(dsk_addr == 32'h1000, "R7 address stored", dsk_addr, 32'h1000);
    @(negedge clk); dsk_done = 1; dsk_len = 16'h20;
    @(negedge clk); dsk_done = 0;
    chk(dsk_addr == 32'h1020, "R8 address advanced", dsk_addr, 32'h1020);
    rd(5'h00, v);
    chk(v == 32'hA4000011, "R8 pending bit", v, 32'hA4000011);
    chk(dsk_irq == 0, "R8 done leaves irq", 32'(dsk_irq), 0);
    wr(5'h07, 32'hFFFFFFF0);
    @(negedge clk); dsk_done = 1; dsk_len = 16'hFFFF;
    @(negedge clk); dsk_done = 0;
    chk(dsk_addr == 32'h0000FFEF, "R8 wraparound", dsk_addr, 32'h0000FFEF);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 5'h04; bus_wdata = 32'h500;
    dsk_done = 1; dsk_len = 16'h8;
    @(negedge clk); bus_sel = 0; bus_we = 0; dsk_done = 0;
    chk(dsk_addr == 32'h500, "R8 write wins over done", dsk_addr, 32'h500);
  endtask

  task automatic t_disk_irq();
    logic [31:0] v;
    do_reset();
    @(negedge clk); dsk_irq_raise = 1;
    @(negedge clk); dsk_irq_raise = 0;
    chk(dsk_irq == 1, "R9 raise without enable", 32'(dsk_irq), 1);
    rd(5'h00, v);
    chk(v == 32'hA0000001, "R9 pending set", v, 32'hA0000001);
    wr(5'h00, 32'h10);
    chk(dsk_irq == 1, "R4 enabled write keeps irq", 32'(dsk_irq), 1);
    wr(5'h00, 32'h0);
    chk(dsk_irq == 0, "R4 enable clear drops irq", 32'(dsk_irq), 0);
    @(negedge clk); dsk_irq_raise = 1; bus_sel = 1; bus_we = 1; bus_addr = 5'h00; bus_wdata = 32'h1;
    @(negedge clk); dsk_irq_raise = 0; bus_sel = 0; bus_we = 0;
    chk(dsk_irq == 1, "R4 raise beats disable write", 32'(dsk_irq), 1);
    @(negedge clk); dsk_irq_clear = 1;
    @(negedge clk); dsk_irq_clear = 0;
    rd(5'h00, v);
    chk(dsk_irq == 0 && v[0] == 0, "R9 clear", {31'h0, dsk_irq}, 0);
    @(negedge clk); dsk_irq_raise = 1; dsk_irq_clear = 1;
    @(negedge clk); dsk_irq_raise = 0; dsk_irq_clear = 0;
    rd(5'h00, v);
    chk(dsk_irq == 0 && v[0] == 0, "R9 clear wins", {v[0], dsk_irq}, 0);
  endtask

  task automatic t_net_irq();
    do_reset();
    @(negedge clk); net_irq_raise = 1;
    @(negedge clk); net_irq_raise = 0;
    chk(net_irq == 1 && dsk_irq == 0, "R10 net raise isolated", {net_irq, dsk_irq}, 2);
    wr(5'h10, 32'h10);
    chk(net_irq == 1, "R4 net enabled write keeps", 32'(net_irq), 1);
    wr(5'h10, 32'h0);
    chk(net_irq == 0, "R4 net disable drops", 32'(net_irq), 0);
    @(negedge clk); net_irq_raise = 1; net_irq_clear = 1;
    @(negedge clk); net_irq_raise = 0; net_irq_clear = 0;
    chk(net_irq == 0, "R10 clear wins", 32'(net_irq), 0);
    @(negedge clk); net_irq_raise = 1;
    @(negedge clk); net_irq_raise = 0; net_irq_clear = 1;
    @(negedge clk); net_irq_clear = 0;
    chk(net_irq == 0, "R10 net clear", 32'(net_irq), 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    int idx [5] = '{2, 3, 5, 6, 7};
    do_reset();
    foreach (idx[k]) wr(5'(idx[k] * 4 + 3), 32'h1234_0000 + 32'(idx[k]));
    foreach (idx[k]) begin
      rd(5'(idx[k] * 4), v);
      chk(v == 32'h1234_0000 + 32'(idx[k]), "R11 plain storage", v, 32'h1234_0000 + 32'(idx[k]));
    end
    chk(net_base == 32'h1234_0007, "R11 net base port", net_base, 32'h1234_0007);
    rd(5'h00, v);
    chk(v == 32'hA0000000, "R1 plain writes leave reg0", v, 32'hA0000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ctrl_writes();
    t_loaded_done();
    t_disk_irq();
    t_net_irq();
    t_plain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule